// File: doc/BRIEF.md
# Camera Pixel Packer with YUV Byte Reorder

This block takes one pixel per beat from a camera receiver's pixel output and builds 128-bit words for a DMA stream port. Each pixel goes into a container of 8, 16 or 32 bits. The container size and a six-bit data type code are set in a context register. The data type decides how many low bits of the pixel are kept, and the kept bits are zero-extended. Containers fill each output word from byte 0 upward, which is little-endian, and a full word is emitted on a valid/ready stream.

When the data type is 8-bit YUV 4:2:2 and the container is 8 bits, the block can permute the bytes inside every aligned group of four. The incoming order within a group is U0, Y0, V0, Y1. Four swap modes choose where each of these bytes lands in memory. For any other data type the swap field has no effect.

An end-of-frame flag on the last pixel flushes a partly filled word, pads it with zeros and marks it as last. A control register holds the whole pixel path in reset. Clearing the enable bit in the context register has the same effect. While the path is held in either way, any partial word and any word waiting at the output are discarded.

Top module: `pix_packer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 0, because the control register (offset 0x0, bit 0) resets to 0 and so holds the pixel path in reset.
- R2: in_ready can be 1 only when control bit 0 is 1 and the enable bit (bit 31) of the context register at offset 0x4 is 1. The other context fields are: swap mode in bits 27:26, container size in bits 21:20, data type in bits 5:0.
- R3: Container size code 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Each pixel is stored at the next free byte of the word, least significant byte first. Only the data type's bits are kept: 0x2A and 0x1E keep 8 bits, 0x2B keeps 10, 0x22 keeps 16, 0x24 keeps 24, and any other code keeps the whole container. The kept bits are zero-extended, then cut to the container. Byte 0 of the word is out_data[7:0].
- R4: With data type 0x1E and container code 0, input bytes are grouped in fours at positions P0..P3 (U0, Y0, V0, Y1). Word lanes 0..3 of each group then hold: mode 3 = P0,P1,P2,P3; mode 2 = P2,P1,P0,P3; mode 1 = P1,P0,P3,P2; mode 0 = P1,P2,P3,P0.
- R5: For every other data type, or for 0x1E with a container wider than 8 bits, the swap mode has no effect on the output.
- R6: A word is emitted as soon as its 16 bytes are filled. The pixel flagged with in_eof ends the word holding it, and that word has out_last=1. Bytes not filled read as zero. A frame that exactly fills its last word produces no extra word. out_last is 0 on all other words.
- R7: While out_valid is 1 and out_ready is 0, out_data and out_last stay constant and in_ready is 0. No pixel is lost or repeated under any pattern of ready and valid.
- R8: While the path is held in reset or disabled, out_valid is forced to 0 and any partial word is discarded. The next frame starts from an empty word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Pixel beat valid |
| in_ready | output | 1 | Pixel beat accepted |
| in_pix | input | 32 | Pixel value, right-aligned |
| in_eof | input | 1 | Marks the last pixel of a frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts output word |
| out_data | output | 128 | Packed output word |
| out_last | output | 1 | Word ends a frame |

## Verification
The assertions assume the sink does not depend on out_valid being kept while the path is disabled. The hold property therefore applies only while the path runs. They also assume the context is not rewritten in the middle of a frame, so every group of YUV bytes and every container stays aligned to its word. The stimulus changes the context only after the last-marked word of a frame has been taken, or while the path is disabled or held in reset. It varies ready and valid gaps only between beats, which keeps all traffic inside these assumptions.

// File: rtl/pp_pkg.sv
package pp_pkg;

  localparam logic [5:0] DT_YUV8   = 6'h1E;
  localparam logic [5:0] DT_RAW8   = 6'h2A;
  localparam logic [5:0] DT_RAW10  = 6'h2B;
  localparam logic [5:0] DT_RGB565 = 6'h22;
  localparam logic [5:0] DT_RGB888 = 6'h24;

  typedef enum logic [1:0] {
    CONT_8   = 2'd0,
    CONT_16  = 2'd1,
    CONT_32  = 2'd2,
    CONT_RSV = 2'd3
  } cont_e;

  typedef struct packed {
    logic       en;
    logic [1:0] swap;
    cont_e      size;
    logic [5:0] dt;
  } ctx_t;

  // bytes occupied by one container
  function automatic logic [2:0] cont_bytes(cont_e s);
    case (s)
      CONT_8:  return 3'd1;
      CONT_16: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // bits of the pixel that survive, data type and container combined
  function automatic logic [31:0] keep_mask(logic [5:0] dt, cont_e s);
    logic [31:0] dm;
    logic [31:0] cm;
    case (dt)
      DT_RAW8, DT_YUV8: dm = 32'h0000_00FF;
      DT_RAW10:         dm = 32'h0000_03FF;
      DT_RGB565:        dm = 32'h0000_FFFF;
      DT_RGB888:        dm = 32'h00FF_FFFF;
      default:          dm = 32'hFFFF_FFFF;
    endcase
    case (s)
      CONT_8:  cm = 32'h0000_00FF;
      CONT_16: cm = 32'h0000_FFFF;
      default: cm = 32'hFFFF_FFFF;
    endcase
    return dm & cm;
  endfunction

  // destination lane inside a four-byte group for input position pos
  function automatic logic [1:0] yuv_lane(logic [1:0] mode, logic [1:0] pos);
    case (mode)
      2'd3: return pos;
      2'd2: return (pos == 2'd1 || pos == 2'd3) ? pos : (2'd2 - pos);
      2'd1: return {pos[1], ~pos[0]};
      default: return pos - 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/pp_cfg.sv
module pp_cfg
  import pp_pkg::*;
#(
  parameter int REG_AW   = 4,
  parameter int CTRL_OFF = 0,
  parameter int CTX_OFF  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              run,
  output ctx_t              ctx
);

  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(CTRL_OFF);
  localparam logic [REG_AW-1:0] A_CTX  = REG_AW'(CTX_OFF);

  logic path_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      path_rel <= 1'b0;
      ctx      <= '{en: 1'b0, swap: 2'd0, size: CONT_8, dt: 6'd0};
    end else if (reg_we) begin
      if (reg_addr == A_CTRL) begin
        path_rel <= reg_wdata[0];
      end
      if (reg_addr == A_CTX) begin
        ctx.en   <= reg_wdata[31];
        ctx.swap <= reg_wdata[27:26];
        ctx.size <= cont_e'(reg_wdata[21:20]);
        ctx.dt   <= reg_wdata[5:0];
      end
    end
  end

  assign run = path_rel & ctx.en;

endmodule

// File: rtl/pp_format.sv
module pp_format
  import pp_pkg::*;
#(
  parameter int FILL_W = 4
) (
  input  ctx_t              ctx,
  input  logic [31:0]       in_pix,
  input  logic [FILL_W-1:0] fill,
  output logic [31:0]       chunk,
  output logic [FILL_W-1:0] off,
  output logic [2:0]        span
);

  logic yuv_path;

  assign yuv_path = (ctx.dt == DT_YUV8) && (ctx.size == CONT_8);

  always_comb begin
    if (yuv_path) begin
      chunk = {24'd0, in_pix[7:0]};
      off   = {fill[FILL_W-1:2], yuv_lane(ctx.swap, fill[1:0])};
      span  = 3'd1;
    end else begin
      chunk = in_pix & keep_mask(ctx.dt, ctx.size);
      off   = fill;
      span  = cont_bytes(ctx.size);
    end
  end

endmodule

// File: rtl/pp_pack.sv
module pp_pack #(
  parameter int OUT_BYTES = 16,
  localparam int OUT_W  = OUT_BYTES * 8,
  localparam int FILL_W = $clog2(OUT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              in_valid,
  input  logic              in_eof,
  input  logic [31:0]       chunk,
  input  logic [FILL_W-1:0] off,
  input  logic [2:0]        span,
  input  logic              out_ready,
  output logic              in_ready,
  output logic [FILL_W-1:0] fill,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_last,
  output logic              accept,
  output logic              word_done
);

  localparam logic [FILL_W:0] FULL = (FILL_W+1)'(OUT_BYTES);

  logic [OUT_W-1:0]  acc;
  logic [OUT_W-1:0]  merged;
  logic [FILL_W:0]   new_fill;
  logic [FILL_W:0]   span_x;

  assign span_x    = {{(FILL_W-2){1'b0}}, span};
  assign in_ready  = run && (!out_valid || out_ready);
  assign accept    = in_valid && in_ready;
  assign new_fill  = {1'b0, fill} + span_x;
  assign word_done = accept && (in_eof || new_fill >= FULL);

  // per-lane placement of the incoming chunk
  for (genvar k = 0; k < OUT_BYTES; k++) begin : g_lane
    localparam logic [FILL_W:0] K = (FILL_W+1)'(k);
    logic [FILL_W:0] rel;
    logic            hit;
    assign rel = K - {1'b0, off};
    assign hit = (K >= {1'b0, off}) && (rel < span_x);
    assign merged[k*8 +: 8] = hit ? chunk[{rel[1:0], 3'b000} +: 8] : acc[k*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (!run) begin
      acc       <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
      if (accept) begin
        if (word_done) begin
          out_data  <= merged;
          out_last  <= in_eof;
          out_valid <= 1'b1;
          acc       <= '0;
          fill      <= '0;
        end else begin
          acc  <= merged;
          fill <= new_fill[FILL_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/pix_packer.sv
module pix_packer
  import pp_pkg::*;
#(
  parameter int REG_AW    = 4,
  parameter int CTRL_OFF  = 0,
  parameter int CTX_OFF   = 4,
  parameter int OUT_BYTES = 16,
  localparam int OUT_W  = OUT_BYTES * 8,
  localparam int FILL_W = $clog2(OUT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_pix,
  input  logic              in_eof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_last
);

  ctx_t              ctx;
  logic              run;
  logic [FILL_W-1:0] fill;
  logic [31:0]       chunk;
  logic [FILL_W-1:0] off;
  logic [2:0]        span;
  logic              accept;
  logic              word_done;

  pp_cfg #(.REG_AW(REG_AW), .CTRL_OFF(CTRL_OFF), .CTX_OFF(CTX_OFF)) u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .run(run), .ctx(ctx)
  );

  pp_format #(.FILL_W(FILL_W)) u_fmt (
    .ctx(ctx), .in_pix(in_pix), .fill(fill),
    .chunk(chunk), .off(off), .span(span)
  );

  pp_pack #(.OUT_BYTES(OUT_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .run(run), .in_valid(in_valid), .in_eof(in_eof),
    .chunk(chunk), .off(off), .span(span), .out_ready(out_ready),
    .in_ready(in_ready), .fill(fill), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last),
    .accept(accept), .word_done(word_done)
  );

endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int OUT_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_eof,
  input logic             accept,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_last
);

  assert_ready_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> run);

  assert_eof_marks_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_eof) |=> (out_valid && out_last));

  assert_word_has_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(accept));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && run) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !out_valid);

  // in_valid is observed so the bind carries the full input handshake
  assert_accept_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (in_valid && in_ready));

endmodule

bind pix_packer pp_checker #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .in_valid(in_valid), .in_ready(in_ready),
  .in_eof(in_eof), .accept(accept), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last)
);

// File: tb/pix_packer_test.sv
module pix_packer_test;

  localparam int OB = 16;
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_CTX  = 4'h4;

  // {dt[31:26], size[25:24], mode[23:22], npix[21:14], ready_pat[13:12], seed[11:4], req[3:0]}
  localparam int NV = 11;
  localparam logic [31:0] VEC [0:NV-1] = '{
    {6'h1E, 2'd0, 2'd3, 8'd32, 2'd0, 8'h11, 4'd4},  // R4 identity order, two full words
    {6'h1E, 2'd0, 2'd2, 8'd32, 2'd1, 8'h22, 4'd4},  // R4 mode 2
    {6'h1E, 2'd0, 2'd1, 8'd16, 2'd2, 8'h33, 4'd4},  // R4 mode 1 with gaps
    {6'h1E, 2'd0, 2'd0, 8'd22, 2'd0, 8'h44, 4'd6},  // R6 partial word, partial group
    {6'h2A, 2'd0, 2'd2, 8'd20, 2'd1, 8'h55, 4'd5},  // R5 raw8 ignores swap
    {6'h2B, 2'd1, 2'd0, 8'd13, 2'd2, 8'h66, 4'd3},  // R3 10-bit into 16
    {6'h22, 2'd1, 2'd1, 8'd16, 2'd0, 8'h77, 4'd5},  // R5 16-bit ignores swap
    {6'h24, 2'd2, 2'd2, 8'd9,  2'd1, 8'h88, 4'd3},  // R3 24-bit into 32
    {6'h2A, 2'd3, 2'd0, 8'd6,  2'd2, 8'h99, 4'd3},  // R3 reserved size as 32
    {6'h1E, 2'd1, 2'd0, 8'd10, 2'd0, 8'hAA, 4'd5},  // R5 yuv type in 16-bit container
    {6'h24, 2'd0, 2'd1, 8'd18, 2'd2, 8'hBB, 4'd3}   // R3 24-bit cut to 8
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_pix = '0;
  logic         in_eof = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_last;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [127:0] got_d [0:15];
  logic         got_l [0:15];
  int           got_n;
  logic [7:0]   exp_b [0:255];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pix_packer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_eof(in_eof), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run hung, got %0d expected finish", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic string req_name(int r);
    case (r)
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pix_of(int i, logic [7:0] seed);
    logic [7:0] lo;
    lo = 8'(i * 37) + seed;
    return {seed ^ 8'h5A, 8'(i), 8'(i * 3) ^ seed, lo};
  endfunction

  function automatic logic [31:0] ctx_word(bit en, logic [1:0] md, logic [1:0] sz, logic [5:0] dt);
    return (32'(en) << 31) | (32'(md) << 26) | (32'(sz) << 20) | 32'(dt);
  endfunction

  // which input position lands in lane l of a group (bench view of R4)
  function automatic int src_pos(logic [1:0] md, int l);
    int t3 [4] = '{0, 1, 2, 3};
    int t2 [4] = '{2, 1, 0, 3};
    int t1 [4] = '{1, 0, 3, 2};
    int t0 [4] = '{1, 2, 3, 0};
    case (md)
      2'd3: return t3[l];
      2'd2: return t2[l];
      2'd1: return t1[l];
      default: return t0[l];
    endcase
  endfunction

  function automatic bit rdy_of(logic [1:0] pat);
    case (pat)
      2'd0: return 1'b1;
      2'd1: return cyc[0];
      default: return ((cyc % 5) != 2) && ((cyc % 3) != 0);
    endcase
  endfunction

  task automatic reg_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic drive(int n, logic [7:0] seed, bit eof, logic [1:0] pat);
    int i = 0;
    while (i < n) begin
      @(negedge clk);
      in_valid = !(pat == 2'd2 && (cyc % 7) == 3);
      in_pix   = pix_of(i, seed);
      in_eof   = eof && (i == n - 1);
      #1;
      if (in_valid && in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_eof   = 1'b0;
  endtask

  task automatic collect(logic [1:0] pat);
    bit done = 1'b0;
    got_n = 0;
    while (!done) begin
      @(negedge clk);
      out_ready = rdy_of(pat);
      #1;
      if (out_valid && out_ready) begin
        if (got_n < 16) begin
          got_d[got_n] = out_data;
          got_l[got_n] = out_last;
        end
        got_n++;
        if (out_last) done = 1'b1;
      end
    end
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  // bench model of R3/R4: returns the number of payload bytes
  function automatic int build_exp(logic [5:0] dt, logic [1:0] sz, logic [1:0] md, int n, logic [7:0] seed);
    int cb;
    logic [31:0] m;
    logic [31:0] v;
    for (int k = 0; k < 256; k++) exp_b[k] = 8'h00;
    if (dt == 6'h1E && sz == 2'd0) begin
      for (int k = 0; k < ((n + 3) / 4) * 4; k++) begin
        int idx;
        idx = (k / 4) * 4 + src_pos(md, k % 4);
        if (idx < n) begin
          v = pix_of(idx, seed);
          exp_b[k] = v[7:0];
        end
      end
      return n;
    end
    cb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    case (dt)
      6'h2A, 6'h1E: m = 32'hFF;
      6'h2B:        m = 32'h3FF;
      6'h22:        m = 32'hFFFF;
      6'h24:        m = 32'hFFFFFF;
      default:      m = 32'hFFFFFFFF;
    endcase
    if (cb == 1) m = m & 32'hFF;
    if (cb == 2) m = m & 32'hFFFF;
    for (int i = 0; i < n; i++) begin
      v = pix_of(i, seed) & m;
      for (int b = 0; b < cb; b++) exp_b[i * cb + b] = v[b * 8 +: 8];
    end
    return n * cb;
  endfunction

  task automatic run_case(logic [5:0] dt, logic [1:0] sz, logic [1:0] md, int n,
                          logic [1:0] pat, logic [7:0] seed, string req);
    int nb;
    int nw;
    logic [127:0] ew;
    reg_write(A_CTX, ctx_word(1'b1, md, sz, dt));
    fork
      drive(n, seed, 1'b1, pat);
      collect(pat);
    join
    nb = build_exp(dt, sz, md, n, seed);
    nw = (nb + OB - 1) / OB;
    check(got_n == nw, "R6", {req, " word count"}, 128'(got_n), 128'(nw));
    for (int w = 0; w < nw && w < 16; w++) begin
      for (int b = 0; b < OB; b++) ew[b * 8 +: 8] = exp_b[w * OB + b];
      check(got_d[w] === ew, req, $sformatf("word %0d data", w), got_d[w], ew);
      check(got_l[w] === (w == nw - 1), "R6", $sformatf("word %0d last", w),
            128'(got_l[w]), 128'(w == nw - 1));
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    in_valid = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", 128'(out_valid), 128'(0));
    check(in_ready == 1'b0, "R1", "in_ready after reset", 128'(in_ready), 128'(0));
    in_valid = 1'b0;

    // R2: both enables needed
    reg_write(A_CTRL, 32'h1);
    #1;
    check(in_ready == 1'b0, "R2", "ready with context disabled", 128'(in_ready), 128'(0));
    reg_write(A_CTX, ctx_word(1'b1, 2'd0, 2'd0, 6'h2A));
    #1;
    check(in_ready == 1'b1, "R2", "ready with both enables", 128'(in_ready), 128'(1));
    reg_write(A_CTRL, 32'h0);
    #1;
    check(in_ready == 1'b0, "R2", "ready with path reset held", 128'(in_ready), 128'(0));
    reg_write(A_CTRL, 32'h1);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] e;
      e = VEC[v];
      run_case(e[31:26], e[25:24], e[23:22], int'(e[21:14]), e[13:12], e[11:4],
               req_name(int'(e[3:0])));
    end

    // R8: partial word dropped by path reset
    reg_write(A_CTX, ctx_word(1'b1, 2'd0, 2'd0, 6'h2A));
    out_ready = 1'b1;
    drive(5, 8'hC1, 1'b0, 2'd0);
    reg_write(A_CTRL, 32'h0);
    reg_write(A_CTRL, 32'h1);
    run_case(6'h2A, 2'd0, 2'd0, 3, 2'd0, 8'hC2, "R8");

    // R7 then R8: pending word held under back-pressure, then discarded
    out_ready = 1'b0;
    drive(16, 8'hD1, 1'b0, 2'd0);
    in_valid = 1'b1;
    #1;
    check(out_valid == 1'b1, "R7", "word pending while sink stalls", 128'(out_valid), 128'(1));
    check(in_ready == 1'b0, "R7", "input stalled behind full output", 128'(in_ready), 128'(0));
    in_valid = 1'b0;
    reg_write(A_CTX, ctx_word(1'b0, 2'd0, 2'd0, 6'h2A));
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R8", "pending word dropped on disable", 128'(out_valid), 128'(0));
    out_ready = 1'b1;
    run_case(6'h2A, 2'd0, 2'd0, 4, 2'd0, 8'hD2, "R8");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule